// File: doc/BRIEF.md
# Banked Memory Window Controller

This block sits between an 8-bit processor with a 16-bit address bus and external ROM and RAM devices that each decode 19 address lines. The processor loads a one-byte bank register by writing to one decoded address. When the processor addresses the upper 32K half of its space, the register's low nibble supplies physical address lines 15 to 18. Its top bit chooses whether the ROM or the RAM answers. The lower 32K half always maps to the first 32K of RAM. This gives the processor a movable 32K window into 512K of each device.

Writes to the register are handled by a two-state machine. In `WR_IDLE` the block waits. The transition `IDLE_TO_ARMED` fires when the write strobe goes low at the register address, and the data byte is captured. In `WR_ARMED` the block keeps capturing data while the strobe stays low. The transition `ARMED_TO_IDLE` fires when the strobe is released, and the last captured byte is committed to the register at that point. Reset clears the register. After reset the upper window therefore shows bank 0 of the ROM, so the processor fetches its reset vector at 0xFFFC/0xFFFD from ROM.

Top module: `bnk_window`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0x00 and `rom_cs` is 1 for any upper-half address.
- R2: For a CPU address with bit 15 = 1, `phys_addr[15]`, `[16]`, `[17]` and `[18]` equal register bits 0, 1, 2 and 3 respectively, so bank code n maps to physical base n × 0x8000.
- R3: For an upper-half address, register bit 7 = 0 gives `rom_cs`=1 and `ram_cs`=0, and bit 7 = 1 gives `rom_cs`=0 and `ram_cs`=1. Exactly one select is high at all times.
- R4: For a CPU address with bit 15 = 0, `phys_addr[18:15]` is 0 and `ram_cs` is 1, whatever the register holds.
- R5: `phys_addr[14:0]` always equals `cpu_addr[14:0]`.
- R6: The register changes only on the release of `cpu_wr_n`. While the strobe is held low it keeps its old value. After the release it holds the byte present on the last cycle the strobe was low.
- R7: A strobe at any address other than the parameter `REG_ADDR` leaves the register unchanged.
- R8: Register bits 4 to 6 are stored and appear on `bank_q`, but they change neither `phys_addr` nor the selects.
- R9: After reset, CPU addresses 0xFFFC and 0xFFFD map to ROM physical addresses 0x07FFC and 0x07FFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr_n | input | 1 | Active-low write strobe |
| phys_addr | output | 19 | Physical address to ROM and RAM |
| rom_cs | output | 1 | ROM select, active high |
| ram_cs | output | 1 | RAM select, active high |
| bank_q | output | 8 | Current register contents |

## Verification
The assertions assume the write strobe stays low for at least one clock edge, with the register address and data stable at that edge. They also assume the strobe is released for at least one edge before the next write. They further assume the address does not leave `REG_ADDR` while a write is in progress. The stimulus honours these assumptions: every write holds address and data from the cycle the strobe falls until the cycle after it rises. All inputs change only at falling clock edges.

// File: rtl/bnk_pkg.sv
package bnk_pkg;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_ARMED = 1'b1
    } wr_state_e;

endpackage

// File: rtl/bnk_wr_fsm.sv
module bnk_wr_fsm
    import bnk_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [15:0] REG_ADDR = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cpu_wr_n,
    output logic          commit,
    output logic [DW-1:0] commit_data
);

    wr_state_e     state_q;
    wr_state_e     state_d;
    logic [DW-1:0] hold_q;
    logic          addr_hit;

    assign addr_hit = (cpu_addr == AW'(REG_ADDR));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:  if (!cpu_wr_n && addr_hit) state_d = WR_ARMED; // IDLE_TO_ARMED
            WR_ARMED: if (cpu_wr_n)              state_d = WR_IDLE;  // ARMED_TO_IDLE
            default:                             state_d = WR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // capture data on every edge the strobe is low while armed or arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   hold_q <= '0;
        else if (state_d == WR_ARMED && !cpu_wr_n)    hold_q <= cpu_data;
    end

    // outputs
    always_comb begin
        commit      = 1'b0;
        commit_data = hold_q;
        unique case (state_q)
            WR_IDLE:  commit = 1'b0;
            WR_ARMED: commit = cpu_wr_n;
            default:  commit = 1'b0;
        endcase
    end

    AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cpu_wr_n && !$past(cpu_wr_n))); // R6

    AST_ARM_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_IDLE && state_d == WR_ARMED) |-> addr_hit); // R7

endmodule

// File: rtl/bnk_reg.sv
module bnk_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] bank_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bank_q <= '0;
        else if (load) bank_q <= load_data;
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q)); // R6

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bank_q == $past(load_data))); // R6

endmodule

// File: rtl/bnk_xlate.sv
module bnk_xlate #(
    parameter int CPU_AW  = 16,
    parameter int PHYS_AW = 19,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DW-1:0]      bank_q,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               rom_cs,
    output logic               ram_cs
);

    localparam int WIN_W   = CPU_AW - 1;
    localparam int BANK_W  = PHYS_AW - WIN_W;
    localparam int SEL_BIT = DW - 1;

    logic upper;
    assign upper = cpu_addr[CPU_AW-1];

    assign phys_addr[WIN_W-1:0] = cpu_addr[WIN_W-1:0];

    for (genvar i = 0; i < BANK_W; i++) begin : g_bank
        assign phys_addr[WIN_W+i] = upper & bank_q[i];
    end

    assign rom_cs = upper & ~bank_q[SEL_BIT];
    assign ram_cs = ~upper | bank_q[SEL_BIT];

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_cs, ram_cs}) == 1); // R3

    AST_LOW_HALF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[CPU_AW-1] |-> (ram_cs && phys_addr[PHYS_AW-1:WIN_W] == '0)); // R4

    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]); // R5

endmodule

// File: rtl/bnk_window.sv
module bnk_window #(
    parameter int          CPU_AW   = 16,
    parameter int          PHYS_AW  = 19,
    parameter int          DW       = 8,
    parameter logic [15:0] REG_ADDR = 16'h0200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DW-1:0]      cpu_data,
    input  logic               cpu_wr_n,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               rom_cs,
    output logic               ram_cs,
    output logic [DW-1:0]      bank_q
);

    logic          commit;
    logic [DW-1:0] commit_data;

    bnk_wr_fsm #(
        .AW       (CPU_AW),
        .DW       (DW),
        .REG_ADDR (REG_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .cpu_wr_n    (cpu_wr_n),
        .commit      (commit),
        .commit_data (commit_data)
    );

    bnk_reg #(
        .DW (DW)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (commit),
        .load_data (commit_data),
        .bank_q    (bank_q)
    );

    bnk_xlate #(
        .CPU_AW  (CPU_AW),
        .PHYS_AW (PHYS_AW),
        .DW      (DW)
    ) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .bank_q    (bank_q),
        .phys_addr (phys_addr),
        .rom_cs    (rom_cs),
        .ram_cs    (ram_cs)
    );

    AST_REG_STABLE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr_n && !$past(cpu_wr_n)) |-> $stable(bank_q)); // R6

endmodule

// File: tb/bnk_window_tb.sv
`timescale 1ns/1ps
module bnk_window_tb;

    localparam logic [15:0] REG_A = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr_n = 1'b1;
    logic [18:0] phys_addr;
    logic        rom_cs;
    logic        ram_cs;
    logic [7:0]  bank_q;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bnk_window #(.REG_ADDR(REG_A)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_wr_n  (cpu_wr_n),
        .phys_addr (phys_addr),
        .rom_cs    (rom_cs),
        .ram_cs    (ram_cs),
        .bank_q    (bank_q)
    );

    // {reg value[44:37], cpu addr[36:21], expected phys[20:2], rom[1], ram[0]}
    localparam logic [44:0] VEC [0:8] = '{
        {8'h00, 16'hFFFC, 19'h07FFC, 1'b1, 1'b0},  // R2 R3 bank 0 ROM
        {8'h01, 16'h8000, 19'h08000, 1'b1, 1'b0},  // R2 bank 1
        {8'h8F, 16'hC123, 19'h7C123, 1'b0, 1'b1},  // R2 R3 bank 15 RAM
        {8'h85, 16'h8001, 19'h28001, 1'b0, 1'b1},  // R2 R3 bank 5 RAM
        {8'h0A, 16'hFFFF, 19'h57FFF, 1'b1, 1'b0},  // R2 R5 bank 10 ROM
        {8'h8F, 16'h1234, 19'h01234, 1'b0, 1'b1},  // R4 low half ignores reg
        {8'h00, 16'h7FFF, 19'h07FFF, 1'b0, 1'b1},  // R4 low half top
        {8'hF3, 16'h8000, 19'h18000, 1'b0, 1'b1},  // R8 bits 4-6 set, RAM
        {8'h73, 16'h9000, 19'h19000, 1'b1, 1'b0}   // R8 bits 4-6 set, ROM
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr_n = 1'b0;
        @(negedge clk);
        cpu_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic look(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: during reset
        repeat (3) @(negedge clk);
        look(16'hFFFC);
        check("R1 bank_q in reset", bank_q, 8'h00);
        check("R1 rom_cs in reset", rom_cs, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset vector from ROM
        look(16'hFFFC);
        check("R9 phys FFFC", phys_addr, 19'h07FFC);
        check("R9 rom FFFC", rom_cs, 1'b1);
        look(16'hFFFD);
        check("R9 phys FFFD", phys_addr, 19'h07FFD);
        check("R1 bank_q after reset", bank_q, 8'h00);

        // vector table walk
        for (int i = 0; i < 9; i++) begin
            wr(REG_A, VEC[i][44:37]);
            look(VEC[i][36:21]);
            check("R2/R8 bank_q", bank_q, VEC[i][44:37]);
            check("R2/R4/R5 phys", phys_addr, VEC[i][20:2]);
            check("R3 rom_cs", rom_cs, VEC[i][1]);
            check("R3 ram_cs", ram_cs, VEC[i][0]);
        end

        // R6: strobe held low keeps old value; release commits last byte
        wr(REG_A, 8'h02);
        @(negedge clk);
        cpu_addr = REG_A;
        cpu_data = 8'h84;
        cpu_wr_n = 1'b0;
        @(negedge clk);
        cpu_data = 8'h86;
        @(negedge clk);
        @(negedge clk);
        check("R6 hold while low", bank_q, 8'h02);
        cpu_wr_n = 1'b1;
        @(negedge clk);
        check("R6 commit on release", bank_q, 8'h86);
        look(16'h8010);
        check("R6 phys after commit", phys_addr, 19'h30010);

        // R7: other address ignored
        wr(REG_A + 16'h0001, 8'h0F);
        look(16'hA000);
        check("R7 bank_q unchanged", bank_q, 8'h86);
        check("R7 phys unchanged", phys_addr, 19'h32000);
        check("R7 ram still", ram_cs, 1'b1);

        // R4 with a RAM/bank-15 value loaded
        wr(REG_A, 8'hFF);
        look(16'h0000);
        check("R4 phys low", phys_addr, 19'h00000);
        check("R4 ram low", ram_cs, 1'b1);

        // R1: reset mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        look(16'hC000);
        check("R1 bank_q cleared", bank_q, 8'h00);
        check("R1 rom after re-reset", rom_cs, 1'b1);
        check("R1 phys after re-reset", phys_addr, 19'h04000);
        @(negedge clk);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule